// File: doc/BRIEF.md
# Flash Completion Polling Controller

This block sits on the host side of a parallel flash device and waits for an embedded program or erase to finish. Once the command sequence has been written elsewhere, the host pulses `start_i` with a valid address, the data byte it expects, and a method selector. The block then reads status from that address again and again over a simple request/valid read port until it reaches a verdict. It ends with a one-cycle `done_o` pulse, and `pass_o` gives the result.

Two methods are supported. Data polling compares bit 7 of each status read with bit 7 of the expected byte. Toggle polling looks for bit 6 to return the same value on two back-to-back reads. In both methods bit 5 is the device's time-limit flag. When it is seen set, the block does not fail at once: it takes a short confirming read sequence first, because the completion bit can change in the same cycle as the flag. A read-attempt budget bounds every run, so a device that never settles still produces a fail verdict.

Top module: `flash_done_poller`

## Requirements
- R1: A `start_i` pulse is accepted only while the block is idle. It latches `addr_i`, `expect_i` and `mode_i`. A `start_i` pulse while busy changes neither the read address nor the verdict.
- R2: `rd_req_o` rises the cycle after `start_i`, or the cycle after a non-final read is evaluated. It stays high with `rd_addr_o` unchanged until `rd_valid_i` is sampled high. `rd_addr_o` always equals the latched address.
- R3: With `mode_i`=0 (data polling), a read whose bit 7 equals bit 7 of the expected byte gives a pass verdict with no further read.
- R4: With `mode_i`=0, a read whose bit 7 differs while bit 5 is 0 triggers another read.
- R5: With `mode_i`=0, a mismatching read with bit 5 set triggers exactly one more read. That read decides the run: pass if its bit 7 matches, fail otherwise.
- R6: With `mode_i`=1 (toggle polling), the first read never decides. A later read whose bit 6 equals bit 6 of the read just before it gives a pass.
- R7: With `mode_i`=1, a read whose bit 6 differs from the previous read's bit 6 while bit 5 is set starts a confirming pair of two fresh reads. The run passes only if bit 6 is the same in both reads of the pair, and fails otherwise.
- R8: No run issues more than `MAX_READS` reads. A run with no verdict after that many reads ends with a fail.
- R9: `busy_o` is high from the cycle after an accepted start until the verdict. `done_o` is then high for exactly one cycle with `busy_o` low. `pass_o` is high only together with `done_o`.
- R10: After reset, `rd_req_o`, `busy_o`, `done_o` and `pass_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a polling run |
| mode_i | input | 1 | 0 = data polling, 1 = toggle polling |
| addr_i | input | AW | Valid address to poll |
| expect_i | input | 8 | Expected data byte |
| rd_req_o | output | 1 | Read request, held until valid |
| rd_addr_o | output | AW | Read address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 8 | Read status byte |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle verdict pulse |
| pass_o | output | 1 | Verdict is pass (valid with done_o) |

## Verification
The bench targets the confirming reads after the time-limit flag is seen. In one case the recheck matches, and a design that failed straight away on the flag would report fail. In another it does not match, and a design that kept polling would give too many reads or a late pass. In toggle mode the confirming pair must be two fresh reads. A design that compared against the pre-flag value would pass where it must fail. The bench also runs a device that never settles, to expose an off-by-one in the read budget. It also pulses a start in mid-run to catch a design that re-latches its address or restarts.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } fc_state_e;

  typedef enum logic {
    MODE_DATA   = 1'b0,
    MODE_TOGGLE = 1'b1
  } fc_mode_e;

  localparam int unsigned BIT_DATA = 7;
  localparam int unsigned BIT_TGL  = 6;
  localparam int unsigned BIT_TMO  = 5;
endpackage

// File: rtl/fc_read_port.sv
module fc_read_port #(
  parameter int unsigned AW = 24,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic          issue_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_valid_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [DW-1:0] data_o,
  output logic          data_vld_o
);
  logic [AW-1:0] addr_q;
  logic          req_q, req_d;
  logic [DW-1:0] data_q;
  logic          vld_q, vld_d;
  logic          hs;

  assign hs = req_q && rd_valid_i;

  always_comb begin
    req_d = req_q;
    if (hs)      req_d = 1'b0;
    if (issue_i) req_d = 1'b1;
    vld_d = hs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      req_q  <= 1'b0;
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      if (load_i) addr_q <= addr_i;
      if (hs)     data_q <= rd_data_i;
      req_q <= req_d;
      vld_q <= vld_d;
    end
  end

  assign rd_req_o   = req_q;
  assign rd_addr_o  = addr_q;
  assign data_o     = data_q;
  assign data_vld_o = vld_q;

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !rd_valid_i) |=> (req_q && $stable(addr_q)));
  assert_no_issue_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |-> !req_q);
endmodule

// File: rtl/fc_attempt_ctr.sv
module fc_attempt_ctr #(
  parameter int unsigned MAX_READS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned CW = $clog2(MAX_READS + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc_i) cnt_d = cnt_q + 1'b1;
    if (clr_i) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == CW'(MAX_READS - 1));

  assert_budget_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_READS));
endmodule

// File: rtl/fc_poll_ctrl.sv
module fc_poll_ctrl
  import fc_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic [DW-1:0] expect_i,
  input  logic [DW-1:0] data_i,
  input  logic          data_vld_i,
  input  logic          last_i,
  output logic          load_o,
  output logic          issue_o,
  output logic          clr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o
);
  fc_state_e state_q, state_d;
  fc_mode_e  mode_q, mode_d;
  logic exp7_q, exp7_d;
  logic recheck_q, recheck_d;
  logic have_prev_q, have_prev_d;
  logic prev6_q, prev6_d;
  logic pass_q, pass_d;
  logic fin, ok;
  logic d7, d6, d5;

  assign d7 = data_i[BIT_DATA];
  assign d6 = data_i[BIT_TGL];
  assign d5 = data_i[BIT_TMO];

  always_comb begin
    state_d     = state_q;
    mode_d      = mode_q;
    exp7_d      = exp7_q;
    recheck_d   = recheck_q;
    have_prev_d = have_prev_q;
    prev6_d     = prev6_q;
    pass_d      = pass_q;
    load_o      = 1'b0;
    issue_o     = 1'b0;
    clr_o       = 1'b0;
    fin         = 1'b0;
    ok          = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o      = 1'b1;
          clr_o       = 1'b1;
          issue_o     = 1'b1;
          mode_d      = fc_mode_e'(mode_i);
          exp7_d      = expect_i[BIT_DATA];
          recheck_d   = 1'b0;
          have_prev_d = 1'b0;
          pass_d      = 1'b0;
          state_d     = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (data_vld_i) begin
          if (mode_q == MODE_DATA) begin
            if (d7 == exp7_q) begin
              fin = 1'b1;
              ok  = 1'b1;
            end else if (recheck_q) begin
              fin = 1'b1;
            end else if (d5) begin
              recheck_d = 1'b1;
            end
          end else begin
            if (!have_prev_q) begin
              have_prev_d = 1'b1;
              prev6_d     = d6;
            end else if (d6 == prev6_q) begin
              fin = 1'b1;
              ok  = 1'b1;
            end else if (recheck_q) begin
              fin = 1'b1;
            end else if (d5) begin
              recheck_d   = 1'b1;
              have_prev_d = 1'b0;
            end else begin
              prev6_d = d6;
            end
          end
          if (!fin && last_i) fin = 1'b1;
          if (fin) begin
            pass_d  = ok;
            state_d = ST_DONE;
          end else begin
            issue_o = 1'b1;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      mode_q      <= MODE_DATA;
      exp7_q      <= 1'b0;
      recheck_q   <= 1'b0;
      have_prev_q <= 1'b0;
      prev6_q     <= 1'b0;
      pass_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      mode_q      <= mode_d;
      exp7_q      <= exp7_d;
      recheck_q   <= recheck_d;
      have_prev_q <= have_prev_d;
      prev6_q     <= prev6_d;
      pass_q      <= pass_d;
    end
  end

  assign busy_o = (state_q == ST_WAIT);
  assign done_o = (state_q == ST_DONE);
  assign pass_o = done_o && pass_q;

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_o));
  assert_busy_needs_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
  assert_recheck_decides_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && data_vld_i && recheck_q && mode_q == MODE_DATA) |=> done_o);
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller #(
  parameter int unsigned AW        = 24,
  parameter int unsigned DW        = 8,
  parameter int unsigned MAX_READS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] expect_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_valid_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o
);
  logic          rst_s1_q, rst_sync_n;
  logic          load, issue, clr, last, data_vld;
  logic [DW-1:0] data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  fc_read_port #(.AW(AW), .DW(DW)) port_i (
    .clk(clk), .rst_n(rst_sync_n), .load_i(load), .addr_i(addr_i),
    .issue_i(issue), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .data_o(data), .data_vld_o(data_vld)
  );

  fc_attempt_ctr #(.MAX_READS(MAX_READS)) ctr_i (
    .clk(clk), .rst_n(rst_sync_n), .clr_i(clr), .inc_i(data_vld),
    .last_o(last)
  );

  fc_poll_ctrl #(.DW(DW)) ctrl_i (
    .clk(clk), .rst_n(rst_sync_n), .start_i(start_i), .mode_i(mode_i),
    .expect_i(expect_i), .data_i(data), .data_vld_i(data_vld),
    .last_i(last), .load_o(load), .issue_o(issue), .clr_o(clr),
    .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o)
  );

  assert_pass_with_done_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pass_o |-> (done_o && !rd_req_o));
endmodule

// File: tb/flash_done_poller_tb_top.sv
module flash_done_poller_tb_top;
  localparam int AW = 24;
  localparam int MAXR = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic mode_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0] expect_i = '0;
  logic rd_req_o;
  logic [AW-1:0] rd_addr_o;
  logic rd_valid_i = 1'b0;
  logic [7:0] rd_data_i = '0;
  logic busy_o, done_o, pass_o;

  int total = 0;
  int bad = 0;
  logic [7:0] resp [0:31];
  logic [7:0] fill = 8'h00;
  int idx = 0;
  int lat = 1;
  int wait_c = 0;
  int addr_err = 0;
  logic [AW-1:0] exp_addr = '0;
  logic tgl_fill = 1'b0;

  always #4 clk = ~clk;

  flash_done_poller #(.AW(AW), .DW(8), .MAX_READS(MAXR)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .addr_i(addr_i), .expect_i(expect_i), .rd_req_o(rd_req_o),
    .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o)
  );

  initial begin
    forever begin
      @(negedge clk);
      if (rd_valid_i) rd_valid_i = 1'b0;
      else if (rd_req_o) begin
        if (rd_addr_o !== exp_addr) addr_err++;
        if (wait_c >= lat) begin
          rd_valid_i = 1'b1;
          if (idx < 32) rd_data_i = resp[idx];
          else rd_data_i = tgl_fill ? {1'b0, idx[0], 6'h0} : fill;
          idx++;
          wait_c = 0;
        end else wait_c++;
      end
    end
  end

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input bit cond, input string req, input int act, input int expv);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic run_op(input logic m, input logic [AW-1:0] a, input logic [7:0] e,
                        input bit exp_pass, input int exp_reads, input string req,
                        input bit poke);
    int cyc;
    idx = 0; wait_c = 0; addr_err = 0; exp_addr = a;
    @(negedge clk);
    mode_i = m; addr_i = a; expect_i = e; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o === 1'b1 && rd_req_o === 1'b1, "R9", busy_o, 1);
    if (poke) begin
      repeat (2) @(negedge clk);
      mode_i = ~m; addr_i = ~a; expect_i = ~e; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    cyc = 0;
    while (done_o !== 1'b1 && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    check(done_o === 1'b1 && busy_o === 1'b0, "R9", done_o, 1);
    check(pass_o === exp_pass, req, pass_o, exp_pass);
    check(idx == exp_reads, req, idx, exp_reads);
    check(addr_err == 0, "R2", addr_err, 0);
    @(negedge clk);
    check(done_o === 1'b0 && pass_o === 1'b0 && rd_req_o === 1'b0, "R9", done_o, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(rd_req_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0 && pass_o === 1'b0,
          "R10", {rd_req_o, busy_o, done_o, pass_o}, 0);
  endtask

  task automatic t_dpoll_match();
    lat = 3; resp[0] = 8'h80;
    run_op(1'b0, 24'h01_2345, 8'h80, 1'b1, 1, "R3", 1'b0);
    lat = 0; resp[0] = 8'h80; resp[1] = 8'h00;
    run_op(1'b0, 24'h00_0040, 8'h00, 1'b1, 2, "R3", 1'b0);
  endtask

  task automatic t_dpoll_retry();
    lat = 1; resp[0] = 8'h00; resp[1] = 8'h40; resp[2] = 8'h00; resp[3] = 8'h80;
    run_op(1'b0, 24'hAB_CDEF, 8'hFF, 1'b1, 4, "R4", 1'b0);
  endtask

  task automatic t_dpoll_tmo();
    lat = 2; resp[0] = 8'h20; resp[1] = 8'hA0;
    run_op(1'b0, 24'h10_0000, 8'h80, 1'b1, 2, "R5", 1'b0);
    resp[0] = 8'h20; resp[1] = 8'h20; resp[2] = 8'h80;
    run_op(1'b0, 24'h10_0004, 8'h80, 1'b0, 2, "R5", 1'b0);
  endtask

  task automatic t_toggle();
    lat = 1; resp[0] = 8'h40; resp[1] = 8'h00; resp[2] = 8'h00;
    run_op(1'b1, 24'h22_0000, 8'h55, 1'b1, 3, "R6", 1'b0);
    resp[0] = 8'h00; resp[1] = 8'h00;
    run_op(1'b1, 24'h22_0010, 8'h00, 1'b1, 2, "R6", 1'b0);
  endtask

  task automatic t_toggle_tmo();
    lat = 1; resp[0] = 8'h00; resp[1] = 8'h60; resp[2] = 8'h40; resp[3] = 8'h40;
    run_op(1'b1, 24'h33_0000, 8'h00, 1'b1, 4, "R7", 1'b0);
    resp[0] = 8'h00; resp[1] = 8'h60; resp[2] = 8'h00; resp[3] = 8'h40;
    run_op(1'b1, 24'h33_0020, 8'h00, 1'b0, 4, "R7", 1'b0);
  endtask

  task automatic t_budget();
    lat = 0;
    for (int i = 0; i < 32; i++) resp[i] = 8'h00;
    fill = 8'h00; tgl_fill = 1'b0;
    run_op(1'b0, 24'h44_0000, 8'h80, 1'b0, MAXR, "R8", 1'b0);
    for (int i = 0; i < 32; i++) resp[i] = (i % 2 == 1) ? 8'h40 : 8'h00;
    tgl_fill = 1'b1;
    run_op(1'b1, 24'h44_0100, 8'h00, 1'b0, MAXR, "R8", 1'b0);
    tgl_fill = 1'b0;
  endtask

  task automatic t_start_busy();
    lat = 2; resp[0] = 8'h00; resp[1] = 8'h00; resp[2] = 8'h80;
    run_op(1'b0, 24'h55_AAAA, 8'h80, 1'b1, 3, "R1", 1'b1);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) resp[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_dpoll_match();
    t_dpoll_retry();
    t_dpoll_tmo();
    t_toggle();
    t_toggle_tmo();
    t_budget();
    t_start_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule